// File: doc/BRIEF.md
# Segmented Address Translator

The translator maps a 16-bit virtual address onto a 16-bit physical address by way of four segment descriptors. The top two address bits pick a descriptor and the remaining fourteen bits are the offset into that segment. Each descriptor holds a physical base, a bound, a valid flag and a three-bit mask of the permitted access kinds. A request is accepted in any cycle. One cycle later the block returns either the base plus the offset, or a fault with a code that names the check that failed.

Software loads descriptors through a write port that carries a segment index and every field of that descriptor in a single cycle. The lookup uses a descriptor's contents as they stood before any write in the same cycle. After reset every descriptor is invalid, so every request faults until software has loaded a descriptor.

Top module: `seg_xlate`

## Requirements
- R1: After reset, `rsp_valid` is low and all four descriptors are invalid, so any request faults with cause 0.
- R2: `rsp_valid` is high for exactly one cycle, in the cycle after each cycle in which `req_valid` is high, and is low in every other cycle.
- R3: The segment number is `req_vaddr[15:14]` and the offset is `req_vaddr[13:0]`. On success, `rsp_paddr` is the segment base plus the zero-extended offset, modulo 2^16.
- R4: A request that selects a descriptor whose valid flag is clear faults with `rsp_cause` = 0.
- R5: A request whose offset is greater than or equal to the descriptor's 15-bit bound faults with `rsp_cause` = 1. A bound of 0 rejects every offset and a bound of 0x4000 accepts every offset.
- R6: `req_kind` encodes 0 = fetch, 1 = load, 2 = store, and is permitted when bit `req_kind` of the descriptor's mask is set (bit 0 fetch, bit 1 load, bit 2 store). A denied kind faults with `rsp_cause` = 2. Kind 3 is always denied with `rsp_cause` = 2.
- R7: When several checks fail, the cause reported is the first that fails in the order invalid segment, then bound, then permission.
- R8: On a fault, `rsp_fault` is 1 and `rsp_paddr` is 0. On success, `rsp_fault` is 0 and `rsp_cause` is 0.
- R9: A descriptor write takes effect for requests in later cycles. A request in the same cycle as the write uses the previous contents. A write changes only the descriptor named by `cfg_idx`.
- R10: `rsp_paddr`, `rsp_fault` and `rsp_cause` keep their values through cycles that follow a cycle with no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Descriptor write enable |
| cfg_idx | input | 2 | Index of the descriptor to write |
| cfg_base | input | 16 | Physical base |
| cfg_bound | input | 15 | Segment size; valid offsets are below this value |
| cfg_valid | input | 1 | Descriptor valid flag |
| cfg_perm | input | 3 | Permitted kinds: bit 0 fetch, bit 1 load, bit 2 store |
| req_valid | input | 1 | Request strobe |
| req_vaddr | input | 16 | Virtual address |
| req_kind | input | 2 | Access kind: 0 fetch, 1 load, 2 store |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_paddr | output | 16 | Translated address, 0 on a fault |
| rsp_fault | output | 1 | The translation failed |
| rsp_cause | output | 2 | Fault cause: 0 invalid, 1 bound, 2 permission |

## Verification
The assertions assume that `req_valid` and `cfg_we` are 0 or 1 on every clock edge. They also assume that the response fields are read only while `rsp_valid` is high, except for the hold rule of R10. They place no limit on how requests and writes overlap. For that reason the stimulus drives writes and requests in the same cycle, at random, as well as on their own. It draws reserved kind 3 and the extreme bounds 0 and 0x4000. It also biases offsets to fall just below, at and just above each descriptor's bound.

// File: rtl/seg_xlate.sv
module seg_xlate #(
  parameter int VA_W  = 16,
  parameter int SEG_W = 2,
  parameter int PA_W  = 16,
  localparam int OFF_W = VA_W - SEG_W,
  localparam int BND_W = OFF_W + 1,
  localparam int NSEG  = 1 << SEG_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [SEG_W-1:0] cfg_idx,
  input  logic [PA_W-1:0]  cfg_base,
  input  logic [BND_W-1:0] cfg_bound,
  input  logic             cfg_valid,
  input  logic [2:0]       cfg_perm,
  input  logic             req_valid,
  input  logic [VA_W-1:0]  req_vaddr,
  input  logic [1:0]       req_kind,
  output logic             rsp_valid,
  output logic [PA_W-1:0]  rsp_paddr,
  output logic             rsp_fault,
  output logic [1:0]       rsp_cause
);

  localparam logic [1:0] CAUSE_SEG  = 2'd0;
  localparam logic [1:0] CAUSE_BND  = 2'd1;
  localparam logic [1:0] CAUSE_PERM = 2'd2;

  logic [PA_W-1:0]  base_q [NSEG];
  logic [BND_W-1:0] bnd_q  [NSEG];
  logic [2:0]       perm_q [NSEG];
  logic [NSEG-1:0]  vld_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= '0;
      for (int i = 0; i < NSEG; i++) begin
        base_q[i] <= '0;
        bnd_q[i]  <= '0;
        perm_q[i] <= '0;
      end
    end else if (cfg_we) begin
      vld_q[cfg_idx]  <= cfg_valid;
      base_q[cfg_idx] <= cfg_base;
      bnd_q[cfg_idx]  <= cfg_bound;
      perm_q[cfg_idx] <= cfg_perm;
    end
  end

  logic [SEG_W-1:0] seg;
  logic [OFF_W-1:0] off;
  logic             seg_ok, bnd_ok, perm_ok;
  logic [PA_W-1:0]  sum;

  assign seg     = req_vaddr[VA_W-1 -: SEG_W];
  assign off     = req_vaddr[OFF_W-1:0];
  assign seg_ok  = vld_q[seg];
  assign bnd_ok  = {1'b0, off} < bnd_q[seg];
  assign perm_ok = (req_kind != 2'd3) && perm_q[seg][req_kind];
  assign sum     = base_q[seg] + PA_W'(off);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_paddr <= '0;
      rsp_fault <= 1'b0;
      rsp_cause <= CAUSE_SEG;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_fault <= !(seg_ok && bnd_ok && perm_ok);
        rsp_paddr <= (seg_ok && bnd_ok && perm_ok) ? sum : '0;
        rsp_cause <= !seg_ok ? CAUSE_SEG :
                     !bnd_ok ? CAUSE_BND :
                     !perm_ok ? CAUSE_PERM : CAUSE_SEG;
      end
    end
  end

  // R2
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  // R2
  rsp_only_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  // R4
  invalid_seg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !vld_q[seg] |=> rsp_fault && rsp_cause == CAUSE_SEG);
  // R5
  bound_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && vld_q[seg] && ({1'b0, off} >= bnd_q[seg]) |=> rsp_fault && rsp_cause == CAUSE_BND);
  // R8
  fault_zero_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fault |-> rsp_paddr == '0 && rsp_cause != 2'd3);
  // R8
  ok_cause_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_fault |-> rsp_cause == CAUSE_SEG);
  // R10
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> $stable(rsp_paddr) && $stable(rsp_fault) && $stable(rsp_cause));

endmodule

// File: tb/tb_seg_xlate.sv
`timescale 1ns/1ps
module tb_seg_xlate;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 0, cfg_valid = 0, req_valid = 0;
  logic [1:0] cfg_idx = 0, req_kind = 0, rsp_cause;
  logic [15:0] cfg_base = 0, req_vaddr = 0, rsp_paddr;
  logic [14:0] cfg_bound = 0;
  logic [2:0] cfg_perm = 0;
  logic rsp_valid, rsp_fault;

  always #10 clk = ~clk;

  seg_xlate dut (.clk, .rst_n, .cfg_we, .cfg_idx, .cfg_base, .cfg_bound, .cfg_valid,
                 .cfg_perm, .req_valid, .req_vaddr, .req_kind, .rsp_valid, .rsp_paddr,
                 .rsp_fault, .rsp_cause);

  int tests = 0, fails = 0;
  logic [15:0] m_base [4];
  logic [14:0] m_bnd [4];
  logic [2:0]  m_perm [4];
  logic [3:0]  m_vld;
  logic [18:0] last_exp;

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", r, act, exp);
    end
  endtask

  function automatic logic [18:0] expect_of(logic [15:0] va, logic [1:0] k);
    logic [1:0] s = va[15:14];
    logic [13:0] o = va[13:0];
    if (!m_vld[s]) return {1'b1, 2'd0, 16'h0};
    if ({1'b0, o} >= m_bnd[s]) return {1'b1, 2'd1, 16'h0};
    if (k == 2'd3 || !m_perm[s][k]) return {1'b1, 2'd2, 16'h0};
    return {1'b0, 2'd0, 16'(m_base[s] + {2'b0, o})};
  endfunction

  // one cycle: drive at negedge, check after the following posedge
  task automatic step(input logic we, input logic [1:0] idx, input logic [15:0] b,
                      input logic [14:0] bd, input logic v, input logic [2:0] p,
                      input logic rq, input logic [15:0] va, input logic [1:0] k, input string tag);
    logic [18:0] e;
    cfg_we = we; cfg_idx = idx; cfg_base = b; cfg_bound = bd; cfg_valid = v; cfg_perm = p;
    req_valid = rq; req_vaddr = va; req_kind = k;
    e = rq ? expect_of(va, k) : last_exp;
    if (we) begin
      m_vld[idx] = v; m_base[idx] = b; m_bnd[idx] = bd; m_perm[idx] = p;
    end
    @(posedge clk); #2;
    chk("R2", {31'b0, rsp_valid}, {31'b0, rq});
    if (rq && tag == "") begin
      if (!e[18]) tag = "R3";
      else if (e[17:16] == 2'd0) tag = "R4";
      else if (e[17:16] == 2'd1) tag = "R5";
      else tag = "R6";
    end
    if (!rq) tag = "R10";
    chk(tag, {13'b0, rsp_fault, rsp_cause, rsp_paddr}, {13'b0, e});
    last_exp = e;
    @(negedge clk);
  endtask

  task automatic wr(logic [1:0] i, logic [15:0] b, logic [14:0] bd, logic v, logic [2:0] p);
    step(1, i, b, bd, v, p, 0, 0, 0, "");
  endtask
  task automatic rd(logic [15:0] va, logic [1:0] k, string tag);
    step(0, 0, 0, 0, 0, 0, 1, va, k, tag);
  endtask

  task automatic run_all();
    logic [31:0] seed_dummy;
    m_vld = 0; last_exp = 0;
    for (int i = 0; i < 4; i++) begin m_base[i] = 0; m_bnd[i] = 0; m_perm[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk("R1", {31'b0, rsp_valid}, 0);
    for (int s = 0; s < 4; s++) rd({s[1:0], 14'h10}, 2'd1, "R1");
    // directed descriptors: code, data, unused, stack
    wr(0, 16'h4000, 15'h700, 1, 3'b011);
    wr(1, 16'h0000, 15'h500, 1, 3'b111);
    wr(3, 16'h2000, 15'h1000, 1, 3'b111);
    rd({2'd3, 14'h100}, 2'd1, "R3");      // 0x2100
    rd({2'd0, 14'h0ff}, 2'd0, "R3");      // 0x40ff
    rd({2'd2, 14'h0ff}, 2'd1, "R4");
    rd({2'd1, 14'h2000}, 2'd1, "R5");
    rd({2'd1, 14'h4ff}, 2'd2, "R3");
    rd({2'd1, 14'h500}, 2'd2, "R5");
    rd({2'd0, 14'h10}, 2'd2, "R6");       // store to code
    rd({2'd1, 14'h10}, 2'd3, "R6");       // reserved kind
    rd({2'd0, 14'h800}, 2'd2, "R7");      // bound beats permission
    wr(2, 16'hffff, 15'h0, 0, 3'b000);
    rd({2'd2, 14'h800}, 2'd3, "R7");      // invalid beats all
    wr(2, 16'hfff0, 15'h4000, 1, 3'b100);
    rd({2'd2, 14'h3fff}, 2'd2, "R3");     // full bound, wrap
    rd({2'd3, 14'h100}, 2'd1, "R9");      // other descriptor untouched
    wr(1, 16'h0, 15'h0, 1, 3'b111);
    rd({2'd1, 14'h0}, 2'd1, "R5");        // bound 0
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, "R10");
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, "R10");
    // same-cycle write and request: old contents
    step(1, 3, 16'h9000, 15'h10, 0, 3'b000, 1, {2'd3, 14'h5}, 2'd1, "R9");
    rd({2'd3, 14'h5}, 2'd1, "R9");
    seed_dummy = $urandom(32'h5E6);
    for (int n = 0; n < 3000; n++) begin
      logic [1:0] s = 2'($urandom);
      logic [13:0] o;
      logic [14:0] bd;
      int sel = $urandom % 8;
      bd = (sel == 0) ? 15'h0 : (sel == 1) ? 15'h4000 : 15'($urandom % 15'h4001);
      case ($urandom % 4)
        0: o = 14'(m_bnd[s]);
        1: o = 14'(m_bnd[s] - 1);
        2: o = 14'(m_bnd[s] + 1);
        default: o = 14'($urandom);
      endcase
      step(($urandom % 4) == 0, 2'($urandom), 16'($urandom), bd, ($urandom % 5) != 0,
           3'($urandom), ($urandom % 5) != 0, {s, o}, 2'($urandom), "");
    end
  endtask

  initial begin
    logic wd = 0;
    fork
      run_all();
      begin repeat (150000) @(posedge clk); wd = 1; end
    join_any
    if (wd) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule